// File: doc/BRIEF.md
# Dual Masked Calendar Alarm

This block holds two alarm settings and compares each one against the live time and date fields whenever the external timekeeper pulses `tick`. Each alarm has six field registers (seconds, minutes, hours, date, month, day of week). Each field register carries its own match-enable bit, so one alarm can fire on any chosen subset of fields. Firing once a minute, every Tuesday, or at one exact moment of one exact day are all settings of the same hardware.

When an armed alarm matches on a tick, its status flag sets and stays set until the host clears it. A per-alarm control register selects repeat mode and enables the interrupt. In repeat mode the alarm fires again at every matching tick, which gives a periodic interrupt. Outside repeat mode the alarm disarms itself after its first hit. Any later write to one of that alarm's registers arms it again. The block does not count time. It only observes the time fields it is given.

Top module: `cal_alarm_pair`

## Requirements
- R1: After reset every flag is 0, `irq` is 0, and both alarms are disarmed, so ticks set no flag until the alarm is written.
- R2: A write to register address 0 to 6 of an alarm (selected by `wrSel`) arms that alarm from the next cycle onward.
- R3: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week. In these registers, bit 7 is the match enable and bits 6:0 are the value, compared with the zero-extended time field. A field with bit 7 clear always matches. An alarm with all six fields disabled matches on every tick.
- R4: Matching is evaluated only in a cycle where `tick` is 1. With `tick` at 0, no flag sets, whatever the time inputs are.
- R5: A hit on a tick in cycle t makes the flag read 1 from cycle t+1. The flag then holds until it is cleared.
- R6: When repeat mode is off, an alarm disarms after its first hit, and later matching ticks leave its flag clear.
- R7: Register address 6 is the control register: bit 0 selects repeat mode and bit 1 enables the interrupt. In repeat mode, every matching tick sets the flag.
- R8: `clrEn` with `clrMask` bit i clears flag i and leaves the other flags unchanged. A hit in the same cycle as the clear leaves the flag set.
- R9: `irq` is 1 exactly when some flag is set whose interrupt-enable bit is 1. It follows the flags with no added cycle.
- R10: A write to one alarm neither arms nor changes the other alarm.
- R11: A write to register address 7 has no effect and does not arm the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse marking a new time value |
| curSec | input | SEC_W | Current seconds (binary) |
| curMin | input | MIN_W | Current minutes (binary) |
| curHour | input | HOUR_W | Current hours (binary) |
| curDate | input | DATE_W | Current day of month (binary) |
| curMonth | input | MON_W | Current month (binary) |
| curDow | input | DOW_W | Current day of week |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | SEL_W | Alarm index for the write |
| wrAddr | input | 3 | Register address within the alarm |
| wrData | input | 8 | Write data |
| clrEn | input | 1 | Flag clear strobe |
| clrMask | input | NUM_ALARMS | Flags to clear |
| flagVec | output | NUM_ALARMS | Alarm status flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands in the same cycle as a fresh hit on the same alarm. Flags only change on ticks, and a one-shot alarm cannot hit again without a rewrite. The bench therefore keeps the alarm in repeat mode and then drives `tick` with a matching time in the same cycle as `clrEn`. A second hard case is showing that a one-shot alarm stays disarmed. The bench fires the alarm, clears the flag, ticks again on the same matching time, and then writes the other alarm and the unused address before ticking once more. A write to either of those must not re-arm the alarm.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned VAL_W     = 7;
  localparam int unsigned FIELD_CNT = 6;
  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned CTRL_REPEAT = 0;
  localparam int unsigned CTRL_IRQEN  = 1;

  typedef enum logic [ADDR_W-1:0] {
    R_SEC   = 3'd0,
    R_MIN   = 3'd1,
    R_HOUR  = 3'd2,
    R_DATE  = 3'd3,
    R_MONTH = 3'd4,
    R_DOW   = 3'd5,
    R_CTRL  = 3'd6,
    R_NONE  = 3'd7
  } regSelE;

  // strobes from control to datapath, shared by all alarms
  typedef struct packed {
    logic               tick;
    logic [FIELD_CNT:0] regWe;   // one-hot register select, bit FIELD_CNT = control
    logic [REG_W-1:0]   wrData;
  } strobeT;
endpackage

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NUM_ALARMS = 2,
  localparam int unsigned SEL_W = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  wrEn,
  input  logic [SEL_W-1:0]      wrSel,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [REG_W-1:0]      wrData,
  input  logic                  clrEn,
  input  logic [NUM_ALARMS-1:0] clrMask,
  input  logic [NUM_ALARMS-1:0] matchVec,
  input  logic [NUM_ALARMS-1:0] repeatVec,
  output strobeT                strobe,
  output logic [NUM_ALARMS-1:0] wrHitVec,
  output logic [NUM_ALARMS-1:0] setVec,
  output logic [NUM_ALARMS-1:0] clrVec,
  output logic [NUM_ALARMS-1:0] armedVec
);
  logic wrLegal;
  assign wrLegal = wrEn && (wrAddr != R_NONE);

  always_comb begin
    strobe        = '0;
    strobe.tick   = tick;
    strobe.wrData = wrData;
    if (wrLegal) strobe.regWe[wrAddr] = 1'b1;
  end

  assign clrVec = clrEn ? clrMask : '0;

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_arm
    logic armedQ;
    assign wrHitVec[a] = wrLegal && (wrSel == SEL_W'(a));
    assign setVec[a]   = tick && armedQ && matchVec[a];
    always_ff @(posedge clk) begin
      if (!rstN)                            armedQ <= 1'b0;
      else if (wrHitVec[a])                 armedQ <= 1'b1;
      else if (setVec[a] && !repeatVec[a])  armedQ <= 1'b0;
    end
    assign armedVec[a] = armedQ;
  end
endmodule

// File: rtl/cal_alarm_dp.sv
module cal_alarm_dp
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NUM_ALARMS = 2,
  parameter int unsigned SEC_W  = 6,
  parameter int unsigned MIN_W  = 6,
  parameter int unsigned HOUR_W = 5,
  parameter int unsigned DATE_W = 5,
  parameter int unsigned MON_W  = 4,
  parameter int unsigned DOW_W  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                strobe,
  input  logic [NUM_ALARMS-1:0] wrHitVec,
  input  logic [NUM_ALARMS-1:0] setVec,
  input  logic [NUM_ALARMS-1:0] clrVec,
  input  logic [SEC_W-1:0]      curSec,
  input  logic [MIN_W-1:0]      curMin,
  input  logic [HOUR_W-1:0]     curHour,
  input  logic [DATE_W-1:0]     curDate,
  input  logic [MON_W-1:0]      curMonth,
  input  logic [DOW_W-1:0]      curDow,
  output logic [NUM_ALARMS-1:0] matchVec,
  output logic [NUM_ALARMS-1:0] repeatVec,
  output logic [NUM_ALARMS-1:0] flagVec,
  output logic                  irq
);
  logic [VAL_W-1:0]      curVal [FIELD_CNT];
  logic [NUM_ALARMS-1:0] ieVec;

  assign curVal[0] = VAL_W'(curSec);
  assign curVal[1] = VAL_W'(curMin);
  assign curVal[2] = VAL_W'(curHour);
  assign curVal[3] = VAL_W'(curDate);
  assign curVal[4] = VAL_W'(curMonth);
  assign curVal[5] = VAL_W'(curDow);

  for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
    logic [FIELD_CNT-1:0] fieldOk;
    logic [1:0]           ctrlQ;
    logic                 flagQ;

    for (genvar f = 0; f < FIELD_CNT; f++) begin : g_field
      logic [REG_W-1:0] fieldQ;
      always_ff @(posedge clk) begin
        if (!rstN)                               fieldQ <= '0;
        else if (wrHitVec[a] && strobe.regWe[f]) fieldQ <= strobe.wrData;
      end
      assign fieldOk[f] = !fieldQ[REG_W-1] || (fieldQ[VAL_W-1:0] == curVal[f]);
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                       ctrlQ <= '0;
      else if (wrHitVec[a] && strobe.regWe[FIELD_CNT]) ctrlQ <= strobe.wrData[1:0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) flagQ <= 1'b0;
      else       flagQ <= (flagQ && !clrVec[a]) || setVec[a];
    end

    assign matchVec[a]  = &fieldOk;
    assign repeatVec[a] = ctrlQ[CTRL_REPEAT];
    assign ieVec[a]     = ctrlQ[CTRL_IRQEN];
    assign flagVec[a]   = flagQ;
  end

  assign irq = |(flagVec & ieVec);
endmodule

// File: rtl/cal_alarm_pair.sv
module cal_alarm_pair
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NUM_ALARMS = 2,
  parameter int unsigned SEC_W  = 6,
  parameter int unsigned MIN_W  = 6,
  parameter int unsigned HOUR_W = 5,
  parameter int unsigned DATE_W = 5,
  parameter int unsigned MON_W  = 4,
  parameter int unsigned DOW_W  = 3,
  localparam int unsigned SEL_W = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic [SEC_W-1:0]      curSec,
  input  logic [MIN_W-1:0]      curMin,
  input  logic [HOUR_W-1:0]     curHour,
  input  logic [DATE_W-1:0]     curDate,
  input  logic [MON_W-1:0]      curMonth,
  input  logic [DOW_W-1:0]      curDow,
  input  logic                  wrEn,
  input  logic [SEL_W-1:0]      wrSel,
  input  logic [2:0]            wrAddr,
  input  logic [7:0]            wrData,
  input  logic                  clrEn,
  input  logic [NUM_ALARMS-1:0] clrMask,
  output logic [NUM_ALARMS-1:0] flagVec,
  output logic                  irq
);
  strobeT                strobe;
  logic [NUM_ALARMS-1:0] wrHitVec, setVec, clrVec, armedVec, matchVec, repeatVec;

  cal_alarm_ctrl #(.NUM_ALARMS(NUM_ALARMS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrSel(wrSel),
    .wrAddr(wrAddr), .wrData(wrData), .clrEn(clrEn), .clrMask(clrMask),
    .matchVec(matchVec), .repeatVec(repeatVec), .strobe(strobe),
    .wrHitVec(wrHitVec), .setVec(setVec), .clrVec(clrVec), .armedVec(armedVec)
  );

  cal_alarm_dp #(
    .NUM_ALARMS(NUM_ALARMS), .SEC_W(SEC_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
    .DATE_W(DATE_W), .MON_W(MON_W), .DOW_W(DOW_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrHitVec(wrHitVec),
    .setVec(setVec), .clrVec(clrVec), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDate(curDate), .curMonth(curMonth), .curDow(curDow),
    .matchVec(matchVec), .repeatVec(repeatVec), .flagVec(flagVec), .irq(irq)
  );
endmodule

// File: rtl/cal_alarm_pair_chk.sv
module cal_alarm_pair_chk #(
  parameter int unsigned NUM_ALARMS = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  tick,
  input logic                  clrEn,
  input logic [NUM_ALARMS-1:0] wrHitVec,
  input logic [NUM_ALARMS-1:0] setVec,
  input logic [NUM_ALARMS-1:0] repeatVec,
  input logic [NUM_ALARMS-1:0] armedVec,
  input logic [NUM_ALARMS-1:0] flagVec,
  input logic                  irq
);
  AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (armedVec & $past(wrHitVec)) == $past(wrHitVec)); // R2

  AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tick) |-> ((flagVec & ~$past(flagVec)) == '0)); // R4

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrEn) |-> ((flagVec & $past(flagVec)) == $past(flagVec))); // R5

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rstN)
    (armedVec & $past(setVec & ~repeatVec & ~wrHitVec)) == '0); // R6

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagVec != '0)); // R9
endmodule

bind cal_alarm_pair cal_alarm_pair_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .clrEn(clrEn), .wrHitVec(wrHitVec),
  .setVec(setVec), .repeatVec(repeatVec), .armedVec(armedVec),
  .flagVec(flagVec), .irq(irq)
);

// File: tb/cal_alarm_pair_tb.sv
`timescale 1ns/1ps
module cal_alarm_pair_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [5:0] curSec = '0, curMin = '0;
  logic [4:0] curHour = '0, curDate = '0;
  logic [3:0] curMonth = '0;
  logic [2:0] curDow = '0;
  logic       wrEn = 1'b0;
  logic [0:0] wrSel = '0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       clrEn = 1'b0;
  logic [1:0] clrMask = '0;
  logic [1:0] flagVec;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_alarm_pair u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .curSec(curSec), .curMin(curMin),
    .curHour(curHour), .curDate(curDate), .curMonth(curMonth), .curDow(curDow),
    .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr), .wrData(wrData),
    .clrEn(clrEn), .clrMask(clrMask), .flagVec(flagVec), .irq(irq)
  );

  typedef struct packed {
    logic [5:0] s; logic [5:0] m; logic [4:0] h; logic [4:0] d;
    logic [3:0] mo; logic [2:0] w; logic [1:0] exp;
  } vecT;

  // alarm0: repeat, seconds == 30; alarm1: repeat, minutes == 5 and day of week == 2
  localparam vecT VECS [8] = '{
    '{6'd30, 6'd0,  5'd1,  5'd1,  4'd1,  3'd0, 2'b01},
    '{6'd30, 6'd5,  5'd1,  5'd1,  4'd1,  3'd2, 2'b11},
    '{6'd0,  6'd5,  5'd1,  5'd1,  4'd1,  3'd2, 2'b10},
    '{6'd0,  6'd5,  5'd1,  5'd1,  4'd1,  3'd3, 2'b00},
    '{6'd29, 6'd6,  5'd1,  5'd1,  4'd1,  3'd2, 2'b00},
    '{6'd30, 6'd5,  5'd23, 5'd31, 4'd12, 3'd2, 2'b11},
    '{6'd31, 6'd4,  5'd0,  5'd1,  4'd1,  3'd2, 2'b00},
    '{6'd30, 6'd59, 5'd0,  5'd1,  4'd1,  3'd6, 2'b01}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [2:0] addr, input logic [7:0] d);
    wrEn = 1'b1; wrSel = sel; wrAddr = addr; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setTime(input logic [5:0] s, input logic [5:0] m, input logic [4:0] h,
                         input logic [4:0] d, input logic [3:0] mo, input logic [2:0] w);
    curSec = s; curMin = m; curHour = h; curDate = d; curMonth = mo; curDow = w;
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic clearAll();
    clrEn = 1'b1; clrMask = 2'b11;
    @(negedge clk);
    clrEn = 1'b0; clrMask = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", 32'(flagVec), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    setTime(0, 0, 0, 1, 1, 0);
    pulseTick();
    chk("R1 unarmed alarms ignore tick", 32'(flagVec), 0);

    // table setup
    wrReg(0, 3'd0, 8'h80 | 8'd30);
    wrReg(0, 3'd6, 8'h03);
    wrReg(1, 3'd1, 8'h80 | 8'd5);
    wrReg(1, 3'd5, 8'h80 | 8'd2);
    wrReg(1, 3'd6, 8'h03);
    for (int i = 0; i < 8; i++) begin
      setTime(VECS[i].s, VECS[i].m, VECS[i].h, VECS[i].d, VECS[i].mo, VECS[i].w);
      pulseTick();
      chk("R3 R7 table flags", 32'(flagVec), 32'(VECS[i].exp));
      chk("R9 table irq", 32'(irq), 32'(|VECS[i].exp));
      clearAll();
      chk("R8 table clear", 32'(flagVec), 0);
    end

    // R4: matching time without tick
    setTime(30, 0, 0, 1, 1, 0);
    repeat (3) @(negedge clk);
    chk("R4 no tick no flag", 32'(flagVec), 0);
    pulseTick();
    chk("R5 flag one cycle after tick", 32'(flagVec), 32'b01);
    repeat (3) @(negedge clk);
    chk("R5 flag holds", 32'(flagVec), 32'b01);
    chk("R9 irq with enabled flag", 32'(irq), 1);

    // R8: clear together with a new hit keeps the flag
    clrEn = 1'b1; clrMask = 2'b01; tick = 1'b1;
    @(negedge clk);
    clrEn = 1'b0; clrMask = 2'b00; tick = 1'b0;
    chk("R8 set wins over clear", 32'(flagVec), 32'b01);
    clrEn = 1'b1; clrMask = 2'b10;
    @(negedge clk);
    clrEn = 1'b0; clrMask = 2'b00;
    chk("R8 mask spares other flag", 32'(flagVec), 32'b01);
    clrEn = 1'b1; clrMask = 2'b01;
    @(negedge clk);
    clrEn = 1'b0; clrMask = 2'b00;
    chk("R8 masked clear", 32'(flagVec), 0);

    // R9: interrupt disabled
    wrReg(0, 3'd6, 8'h01);
    pulseTick();
    chk("R9 flag set with irq disabled", 32'(flagVec), 32'b01);
    chk("R9 irq stays low", 32'(irq), 0);
    clearAll();

    // R6: one-shot
    wrReg(0, 3'd6, 8'h00);
    pulseTick();
    chk("R6 first hit", 32'(flagVec), 32'b01);
    clearAll();
    pulseTick();
    chk("R6 disarmed after hit", 32'(flagVec), 0);

    // R10: writing the other alarm does not re-arm
    wrReg(1, 3'd6, 8'h03);
    pulseTick();
    chk("R10 other alarm write", 32'(flagVec), 0);

    // R11: address 7 ignored
    wrReg(0, 3'd7, 8'hFF);
    pulseTick();
    chk("R11 address 7 no arm", 32'(flagVec), 0);

    // R2: rewrite re-arms
    wrReg(0, 3'd6, 8'h02);
    pulseTick();
    chk("R2 rewrite re-arms", 32'(flagVec), 32'b01);
    chk("R2 irq on re-armed hit", 32'(irq), 1);
    clearAll();

    // R3: exact date and time 05:23:00 on month 3 day 21
    wrReg(0, 3'd0, 8'h80);
    wrReg(0, 3'd1, 8'h80 | 8'd23);
    wrReg(0, 3'd2, 8'h80 | 8'd5);
    wrReg(0, 3'd3, 8'h80 | 8'd21);
    wrReg(0, 3'd4, 8'h80 | 8'd3);
    wrReg(0, 3'd6, 8'h03);
    setTime(0, 23, 5, 21, 3, 4);
    pulseTick();
    chk("R3 exact match", 32'(flagVec), 32'b01);
    clearAll();
    setTime(0, 23, 5, 21, 4, 4);
    pulseTick();
    chk("R3 month differs", 32'(flagVec), 0);
    setTime(1, 23, 5, 21, 3, 4);
    pulseTick();
    chk("R3 second differs", 32'(flagVec), 0);

    // R3: all fields disabled matches on any tick
    wrReg(1, 3'd1, 8'h05);
    wrReg(1, 3'd5, 8'h02);
    setTime(17, 44, 9, 2, 7, 1);
    pulseTick();
    chk("R3 all disabled matches", 32'(flagVec), 32'b10);
    pulseTick();
    chk("R7 repeat keeps firing", 32'(flagVec), 32'b10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule